// File: doc/BRIEF.md
# Dual-Port Same-Word Collision Guard

This block sits beside a synchronous two-port memory. It watches the requests that both ports present on a shared clock. When the two ports touch the same word in the same cycle and at least one of them writes, it raises a one-cycle busy flag. The flag goes to each port whose transfer cannot be trusted. A reader is flagged when the other port writes, and both ports are flagged when both write. Two reads of the same word are harmless and raise nothing.

The first conflicting address is kept in a capture register, together with a captured bit. Later conflicts still raise busy, but they do not replace the stored address until the register has been read back. Either port reads the register with a request strobe. The result comes back on that port's read-back address lines after the same fixed latency as an ordinary data read. The read-back also clears the captured bit, so the next conflict can be recorded.

Top module: `dp_collision_guard`

## Requirements
- R1: A conflict exists in a clock cycle only when both enables are high, the two addresses are equal, and at least one write enable is high. Unequal addresses, or a low enable on either port, never produce busy.
- R2: When port A writes and port B reads the same address, only `b_busy` rises.
- R3: When port B writes and port A reads the same address, only `a_busy` rises.
- R4: When both ports write the same address in the same cycle, both `a_busy` and `b_busy` rise.
- R5: When both ports read the same address, neither busy flag rises and the capture register is not loaded.
- R6: A busy flag is high in the cycle right after a conflicting cycle. It stays high only for as long as each cycle before it was itself a conflict for that port.
- R7: A conflict that occurs while the captured bit is clear stores the conflicting address and sets the bit. Any conflict while the bit is set leaves the stored address unchanged.
- R8: A read-back request on a port, sampled at a clock edge, makes that port's valid strobe high for exactly one cycle, RD_LAT edges later. The request presents the stored address as it was before that edge. The port's read-back address is zero whenever its valid strobe is low.
- R9: A read-back request from either port clears the captured bit. If a conflict occurs in the same cycle as the request while the bit is already clear, that conflict is still captured and the bit ends set.
- R10: A synchronous active-high reset clears both busy flags, both valid strobes, the stored address and the captured bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | ADDR_W | Port A word address |
| a_bsy_rd | input | 1 | Port A request to read the capture register |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_addr | input | ADDR_W | Port B word address |
| b_bsy_rd | input | 1 | Port B request to read the capture register |
| a_busy | output | 1 | Port A transfer of the previous cycle is not trustworthy |
| a_rb_vld | output | 1 | Port A read-back result valid |
| a_rb_addr | output | ADDR_W | Port A read-back address (zero when not valid) |
| b_busy | output | 1 | Port B transfer of the previous cycle is not trustworthy |
| b_rb_vld | output | 1 | Port B read-back result valid |
| b_rb_addr | output | ADDR_W | Port B read-back address (zero when not valid) |

## Verification
The main sweep tries every combination of both enables, both write enables and both addresses on a three-bit address space. This separates equal-address pairs from near misses, and it separates write/read, read/write, write/write and read/read mixes, so each of the four routing outcomes is reached at every address. Read-back requests are spread through the sweep on both ports at unrelated intervals. The stored address is therefore observed while it is held, while it is reloaded and while it is cleared. Directed sequences add the narrow orderings: a request that lands in the same cycle as a conflict, with the captured bit clear and with it set; a chain of conflicts at different addresses; and a reset in the middle of a capture.

// File: rtl/cg_pkg.sv
package cg_pkg;

  localparam int unsigned NPORT = 2;

  // Port index 0 is port A, index 1 is port B.
  // A port is untrustworthy when the opposite port wrote the shared word.
  function automatic logic [NPORT-1:0] route_busy(input logic we_a, input logic we_b);
    logic [NPORT-1:0] r;
    r[0] = we_b;
    r[1] = we_a;
    return r;
  endfunction

  // Same-word test with at least one writer.
  function automatic logic is_conflict(input logic en_a, input logic en_b,
                                       input logic we_a, input logic we_b,
                                       input logic addr_eq);
    return en_a & en_b & addr_eq & (we_a | we_b);
  endfunction

  // Captured bit: set by the first conflict, dropped by a read-back.
  function automatic logic next_captured(input logic cap, input logic hit, input logic rd);
    return (hit & ~cap) | (cap & ~rd);
  endfunction

endpackage

// File: rtl/cg_match.sv
module cg_match #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  output logic              hit,
  output logic              flag_a,
  output logic              flag_b
);

  logic       same_word;
  logic [1:0] route;

  always_comb begin
    same_word = (a_addr == b_addr);
    hit       = cg_pkg::is_conflict(a_en, b_en, a_we, b_we, same_word);
    route     = cg_pkg::route_busy(a_we, b_we);
    flag_a    = hit & route[0];
    flag_b    = hit & route[1];
  end

endmodule

// File: rtl/cg_capture.sv
module cg_capture #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [ADDR_W-1:0] hit_addr,
  input  logic              rd_any,
  output logic              load,
  output logic              captured,
  output logic [ADDR_W-1:0] stored
);

  assign load = hit & ~captured;

  always_ff @(posedge clk) begin
    if (rst) begin
      captured <= 1'b0;
      stored   <= '0;
    end else begin
      captured <= cg_pkg::next_captured(captured, hit, rd_any);
      if (load) begin
        stored <= hit_addr;
      end
    end
  end

endmodule

// File: rtl/cg_readback.sv
module cg_readback #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [ADDR_W-1:0] value,
  output logic              vld,
  output logic [ADDR_W-1:0] addr
);

  localparam int unsigned LAST = RD_LAT - 1;

  logic              v_q [RD_LAT];
  logic [ADDR_W-1:0] d_q [RD_LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < RD_LAT; s++) begin
        v_q[s] <= 1'b0;
        d_q[s] <= '0;
      end
    end else begin
      v_q[0] <= req;
      d_q[0] <= req ? value : '0;
      for (int s = 1; s < RD_LAT; s++) begin
        v_q[s] <= v_q[s-1];
        d_q[s] <= d_q[s-1];
      end
    end
  end

  assign vld  = v_q[LAST];
  assign addr = d_q[LAST];

endmodule

// File: rtl/dp_collision_guard.sv
module dp_collision_guard #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_bsy_rd,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_bsy_rd,
  output logic              a_busy,
  output logic              a_rb_vld,
  output logic [ADDR_W-1:0] a_rb_addr,
  output logic              b_busy,
  output logic              b_rb_vld,
  output logic [ADDR_W-1:0] b_rb_addr
);

  localparam int unsigned NP = cg_pkg::NPORT;

  // Named internal events, observed by the bound checker.
  logic              hit_now;
  logic              flag_a_now;
  logic              flag_b_now;
  logic              load_now;
  logic              captured_q;
  logic [ADDR_W-1:0] stored_q;
  logic              rd_any;

  logic              req_w   [NP];
  logic              vld_w   [NP];
  logic [ADDR_W-1:0] rbaddr_w[NP];

  assign req_w[0] = a_bsy_rd;
  assign req_w[1] = b_bsy_rd;
  assign rd_any   = a_bsy_rd | b_bsy_rd;

  cg_match #(.ADDR_W(ADDR_W)) u_match (
    .a_en   (a_en),
    .a_we   (a_we),
    .a_addr (a_addr),
    .b_en   (b_en),
    .b_we   (b_we),
    .b_addr (b_addr),
    .hit    (hit_now),
    .flag_a (flag_a_now),
    .flag_b (flag_b_now)
  );

  // Conflicting address: both ports agree, port A's copy is taken.
  cg_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit_now),
    .hit_addr (a_addr),
    .rd_any   (rd_any),
    .load     (load_now),
    .captured (captured_q),
    .stored   (stored_q)
  );

  for (genvar p = 0; p < NP; p++) begin : g_port
    cg_readback #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_rb (
      .clk   (clk),
      .rst   (rst),
      .req   (req_w[p]),
      .value (stored_q),
      .vld   (vld_w[p]),
      .addr  (rbaddr_w[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_busy <= 1'b0;
      b_busy <= 1'b0;
    end else begin
      a_busy <= flag_a_now;
      b_busy <= flag_b_now;
    end
  end

  assign a_rb_vld  = vld_w[0];
  assign a_rb_addr = rbaddr_w[0];
  assign b_rb_vld  = vld_w[1];
  assign b_rb_addr = rbaddr_w[1];

endmodule

// File: rtl/dp_collision_guard_chk.sv
module dp_collision_guard_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              a_en,
  input logic              a_we,
  input logic [ADDR_W-1:0] a_addr,
  input logic              b_en,
  input logic              b_we,
  input logic [ADDR_W-1:0] b_addr,
  input logic              a_busy,
  input logic              b_busy,
  input logic              a_rb_vld,
  input logic [ADDR_W-1:0] a_rb_addr,
  input logic              b_rb_vld,
  input logic [ADDR_W-1:0] b_rb_addr,
  input logic              hit_now,
  input logic              captured_q,
  input logic [ADDR_W-1:0] stored_q,
  input logic              rd_any
);

  AST_A_BUSY_CAUSE: assert property (@(posedge clk) disable iff (rst)
    a_busy |-> $past(a_en && b_en && b_we && (a_addr == b_addr))); // R3

  AST_B_BUSY_CAUSE: assert property (@(posedge clk) disable iff (rst)
    b_busy |-> $past(a_en && b_en && a_we && (a_addr == b_addr))); // R2

  AST_DOUBLE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (a_en && b_en && a_we && b_we && (a_addr == b_addr)) |=> (a_busy && b_busy)); // R4

  AST_READ_PAIR_QUIET: assert property (@(posedge clk) disable iff (rst)
    (a_en && b_en && !a_we && !b_we) |=> (!a_busy && !b_busy)); // R5

  AST_FIRST_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (hit_now && !captured_q) |=> (captured_q && (stored_q == $past(a_addr)))); // R7

  AST_CAPTURE_KEEP: assert property (@(posedge clk) disable iff (rst)
    (captured_q && !rd_any) |=> (captured_q && $stable(stored_q))); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_any && captured_q) |=> !captured_q); // R9

  AST_A_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !a_rb_vld |-> (a_rb_addr == '0)); // R8

  AST_B_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !b_rb_vld |-> (b_rb_addr == '0)); // R8

endmodule

bind dp_collision_guard dp_collision_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .a_en       (a_en),
  .a_we       (a_we),
  .a_addr     (a_addr),
  .b_en       (b_en),
  .b_we       (b_we),
  .b_addr     (b_addr),
  .a_busy     (a_busy),
  .b_busy     (b_busy),
  .a_rb_vld   (a_rb_vld),
  .a_rb_addr  (a_rb_addr),
  .b_rb_vld   (b_rb_vld),
  .b_rb_addr  (b_rb_addr),
  .hit_now    (hit_now),
  .captured_q (captured_q),
  .stored_q   (stored_q),
  .rd_any     (rd_any)
);

// File: tb/tb_dp_collision_guard.sv
`timescale 1ns/1ps
module tb_dp_collision_guard;

  localparam int unsigned AW  = 3;
  localparam int unsigned LAT = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          a_en = 0, a_we = 0, a_bsy_rd = 0;
  logic          b_en = 0, b_we = 0, b_bsy_rd = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic          a_busy, b_busy, a_rb_vld, b_rb_vld;
  logic [AW-1:0] a_rb_addr, b_rb_addr;

  int nvec  = 0;
  int nfail = 0;

  // Reference state, built from the requirements.
  logic          m_cap;
  logic [AW-1:0] m_reg;
  logic          m_av [LAT];
  logic [AW-1:0] m_ad [LAT];
  logic          m_bv [LAT];
  logic [AW-1:0] m_bd [LAT];
  logic          m_abusy, m_bbusy;

  always #2.5 clk = ~clk;

  dp_collision_guard #(.ADDR_W(AW), .RD_LAT(LAT)) dut (
    .clk(clk), .rst(rst),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_bsy_rd(a_bsy_rd),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_bsy_rd(b_bsy_rd),
    .a_busy(a_busy), .a_rb_vld(a_rb_vld), .a_rb_addr(a_rb_addr),
    .b_busy(b_busy), .b_rb_vld(b_rb_vld), .b_rb_addr(b_rb_addr)
  );

  task automatic check(input string what, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    m_cap = 0; m_reg = '0; m_abusy = 0; m_bbusy = 0;
    for (int s = 0; s < LAT; s++) begin
      m_av[s] = 0; m_ad[s] = '0; m_bv[s] = 0; m_bd[s] = '0;
    end
  endtask

  task automatic compare(input string tag);
    check({tag, "/R6 a_busy"}, a_busy, m_abusy);
    check({tag, "/R6 b_busy"}, b_busy, m_bbusy);
    check("R8 a_rb_vld", a_rb_vld, m_av[LAT-1]);
    check("R7/R8/R9 a_rb_addr", a_rb_addr, m_ad[LAT-1]);
    check("R8 b_rb_vld", b_rb_vld, m_bv[LAT-1]);
    check("R7/R8/R9 b_rb_addr", b_rb_addr, m_bd[LAT-1]);
  endtask

  // One clock: drive at the falling edge, update the model, compare at the next falling edge.
  task automatic cyc(input logic ae, input logic awe, input logic [AW-1:0] aa,
                     input logic be, input logic bwe, input logic [AW-1:0] ba,
                     input logic ar, input logic br);
    logic hit;
    string tag;
    a_en = ae; a_we = awe; a_addr = aa; a_bsy_rd = ar;
    b_en = be; b_we = bwe; b_addr = ba; b_bsy_rd = br;
    hit = ae && be && (aa == ba) && (awe || bwe);
    if (ae && be && (aa == ba)) begin
      if (awe && bwe)       tag = "R4";
      else if (awe)         tag = "R2";
      else if (bwe)         tag = "R3";
      else                  tag = "R5";
    end else begin
      tag = "R1";
    end
    @(posedge clk);
    for (int s = LAT - 1; s > 0; s--) begin
      m_av[s] = m_av[s-1]; m_ad[s] = m_ad[s-1];
      m_bv[s] = m_bv[s-1]; m_bd[s] = m_bd[s-1];
    end
    m_av[0] = ar; m_ad[0] = ar ? m_reg : '0;
    m_bv[0] = br; m_bd[0] = br ? m_reg : '0;
    m_abusy = hit && bwe;
    m_bbusy = hit && awe;
    if (hit && !m_cap) begin
      m_reg = aa;
      m_cap = 1;
    end else if (ar || br) begin
      m_cap = 0;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, '0, 0, 0, '0, 0, 0);
  endtask

  task automatic do_reset();
    rst = 1;
    a_en = 0; a_we = 0; a_bsy_rd = 0; b_en = 0; b_we = 0; b_bsy_rd = 0;
    repeat (2) @(posedge clk);
    model_clear();
    @(negedge clk);
    rst = 0;
    check("R10 a_busy", a_busy, 0);
    check("R10 b_busy", b_busy, 0);
    check("R10 a_rb_vld", a_rb_vld, 0);
    check("R10 b_rb_vld", b_rb_vld, 0);
    check("R10 a_rb_addr", a_rb_addr, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    model_clear();
    @(negedge clk);
    do_reset();

    // R10: register starts at zero
    cyc(0, 0, '0, 0, 0, '0, 1, 0);
    idle(LAT);

    // R7: first conflict kept, later ones only raise busy
    cyc(1, 1, 3'd5, 1, 0, 3'd5, 0, 0);   // R2
    cyc(1, 0, 3'd3, 1, 1, 3'd3, 0, 0);   // R3
    cyc(1, 1, 3'd2, 1, 1, 3'd2, 0, 0);   // R4
    cyc(1, 0, 3'd2, 1, 0, 3'd2, 0, 0);   // R5
    cyc(1, 1, 3'd1, 1, 0, 3'd6, 0, 0);   // R1 near miss
    idle(1);                              // R6 busy drops
    cyc(0, 0, '0, 0, 0, '0, 1, 0);       // R8 expect 5
    idle(LAT);

    // R9: after read-back, next conflict captured
    cyc(1, 0, 3'd6, 1, 1, 3'd6, 0, 0);
    cyc(0, 0, '0, 0, 0, '0, 0, 1);       // expect 6
    // R9: request with captured clear plus conflict -> captured
    cyc(1, 1, 3'd1, 1, 0, 3'd1, 1, 0);
    idle(LAT);
    // R9: request with captured set plus conflict -> not captured
    cyc(1, 1, 3'd7, 1, 1, 3'd7, 0, 1);
    cyc(1, 0, 3'd4, 1, 1, 3'd4, 0, 0);
    cyc(0, 0, '0, 0, 0, '0, 1, 1);       // expect 4 on both ports
    idle(LAT);

    // R10: reset in the middle of a capture
    cyc(1, 1, 3'd3, 1, 0, 3'd3, 0, 0);
    do_reset();
    cyc(0, 0, '0, 0, 0, '0, 1, 0);
    idle(LAT);

    // Exhaustive sweep of enables, writes and both addresses
    for (int i = 0; i < 1024; i++) begin
      logic [9:0] v;
      v = i[9:0];
      cyc(v[9], v[8], v[5:3], v[7], v[6], v[2:0], (i % 13) == 0, (i % 17) == 5);
    end
    idle(LAT + 1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule